// File: doc/BRIEF.md
# Queued SPI Master with Per-Frame Attribute Selection

This block is a full-duplex SPI master. Software-side logic writes up to eight clock-and-transfer attribute words, then pushes frames into a four-entry transmit queue. Each queued entry holds a 16-bit data word and a 3-bit selector. The selector names the attribute word that sets the size, clock divider, clock polarity, clock phase and bit order of that one frame. Consecutive frames can therefore run with entirely different shapes on the same pins.

While a frame's bits leave on the serial output, the master samples the serial input. Master and slave registers thus exchange contents. Each completed received word lands in a five-entry receive FIFO, which is read through a show-ahead pop port. The master starts a frame only when both a queued entry and free receive space exist. A full receive FIFO stalls it between frames, so no received word is ever lost.

Top module: `qspi_master`

## Requirements
- R1: An attribute write with `cfg_we` stores `cfg_wdata` into the entry chosen by `cfg_sel`. The fields are bits [7:0] divider, [11:8] size code, [12] clock polarity, [13] clock phase and [14] LSB-first. After reset every entry holds divider 0, size code 15 and zero in every mode bit.
- R2: Every frame uses the attribute entry named by the selector pushed with its data, as read when the frame starts. Frames with different selectors may follow each other directly.
- R3: A size code c gives a frame of c+1 bits when c is 3 or more. Codes 0 to 2 give 4 bits. Data shorter than 16 bits is sent from, and received into, the low bits of the word.
- R4: At the falling edge of `spi_cs_n`, `spi_sck` sits at the polarity level. Every half-period, from chip select low to the first edge and between edges, lasts divider+1 clocks. A frame of n bits makes exactly 2n clock edges. `spi_sck` does not move while `spi_cs_n` stays high.
- R5: With phase 0 the master samples `spi_miso` on leading clock edges and holds `spi_mosi` stable across them. With phase 1 it does the same on trailing edges.
- R6: With LSB-first set, bit 0 travels first in both directions. Otherwise the top bit of the frame travels first.
- R7: Each frame's received bits, reassembled in transfer order, are written as one word into the receive FIFO. Words leave the FIFO in frame order.
- R8: `pop_word` shows the oldest received word in bits [15:0] and zeros in bits [31:16]. `pop_re` removes it.
- R9: A frame starts only when the transmit queue holds an entry and the receive FIFO holds fewer than 5 words. `rx_level` never exceeds 5, and no received word is dropped.
- R10: `spi_cs_n` stays low from one clock-half-period before the first edge until one half-period after the last. Between frames it stays high for at least divider+1 clocks of the finished frame.
- R11: A push while `push_full` is high is discarded and sets the sticky `ovf_err`. The discarded entry never produces a frame.
- R12: A pop while `rx_level` is 0 sets the sticky `unf_err` and leaves `rx_level` unchanged.
- R13: After reset, `spi_cs_n` is high, `rx_level` is 0, and `push_full`, `ovf_err` and `unf_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Attribute write strobe |
| cfg_sel | input | 3 | Attribute entry to write |
| cfg_wdata | input | 15 | Attribute word (fields in R1) |
| push_we | input | 1 | Push strobe for the transmit queue |
| push_word | input | 16 | Data to transmit |
| push_sel | input | 3 | Attribute selector for this frame |
| push_full | output | 1 | Transmit queue is full |
| pop_re | input | 1 | Remove the oldest received word |
| pop_word | output | 32 | Oldest received word, upper half zero |
| rx_level | output | 3 | Words held in the receive FIFO |
| ovf_err | output | 1 | Sticky push-on-full flag |
| unf_err | output | 1 | Sticky pop-on-empty flag |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bound checker watches the per-cycle rules on every cycle. These are the quiet clock while chip select is high, the receive bound and the no-write-when-full guard, frame starts only with free receive space, the zero upper half of `pop_word`, and the setting and stickiness of both error flags. Frame shape needs a whole frame of context, so only the bench scenarios show it. That covers half-period length, edge count, idle polarity, sampling phase, bit order, size clamping and per-frame attribute choice. The bench checks these with a slave model that answers each frame with a known pattern and captures what the master sends. The stall scenario fills the receive FIFO, then the queue, then pushes once more, to show that nothing is lost or invented.

// File: rtl/qspi_pkg.sv
package qspi_pkg;

    localparam int DW     = 16;
    localparam int DIV_W  = 8;
    localparam int FSZ_W  = 4;

    // Attribute word layout, MSB first: lsbf, cpha, cpol, size code, divider
    typedef struct packed {
        logic             lsbf;
        logic             cpha;
        logic             cpol;
        logic [FSZ_W-1:0] fsz;
        logic [DIV_W-1:0] div;
    } attr_t;

    localparam int ATTR_W = $bits(attr_t);

    localparam attr_t ATTR_RESET = '{lsbf: 1'b0, cpha: 1'b0, cpol: 1'b0,
                                     fsz: FSZ_W'(15), div: '0};

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_XFER,
        ST_GAP
    } eng_state_e;

endpackage

// File: rtl/qspi_fifo.sv
module qspi_fifo #(
    parameter  int W     = 16,
    parameter  int DEPTH = 4,
    localparam int LW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [W-1:0]  wdata,
    input  logic          rd,
    output logic [W-1:0]  rdata,
    output logic          full,
    output logic          empty,
    output logic [LW-1:0] level
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [LW-1:0]           cnt;
    } fifo_t;

    fifo_t q, d;
    logic  do_wr, do_rd;

    assign full  = (q.cnt == LW'(DEPTH));
    assign empty = (q.cnt == '0);
    assign level = q.cnt;
    assign rdata = q.mem[q.rp];

    always_comb begin
        d     = q;
        do_wr = wr && !full;
        do_rd = rd && !empty;
        if (do_wr) begin
            d.mem[q.wp] = wdata;
            d.wp        = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (do_rd) begin
            d.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        d.cnt = q.cnt + LW'(do_wr) - LW'(do_rd);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/qspi_attr_bank.sv
module qspi_attr_bank
    import qspi_pkg::*;
#(
    parameter  int N_ATTR = 8,
    localparam int SW     = $clog2(N_ATTR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [SW-1:0] wsel,
    input  attr_t         wattr,
    input  logic [SW-1:0] rsel,
    output attr_t         rattr
);

    attr_t [N_ATTR-1:0] bank_q, bank_d;

    always_comb begin
        bank_d = bank_q;
        if (we) bank_d[wsel] = wattr;
    end

    assign rattr = bank_q[rsel];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ATTR; i++) bank_q[i] <= ATTR_RESET;
        end else begin
            bank_q <= bank_d;
        end
    end

endmodule

// File: rtl/qspi_engine.sv
module qspi_engine
    import qspi_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tx_avail,
    input  logic          rx_room,
    input  logic [DW-1:0] tx_data,
    input  attr_t         tx_attr,
    output logic          tx_take,
    output logic          rx_wr,
    output logic [DW-1:0] rx_data,
    output logic          sck,
    output logic          cs_n,
    output logic          mosi,
    input  logic          miso
);

    localparam int IW = $clog2(DW + 1);
    localparam int HW = $clog2(2 * DW + 2);
    localparam int BW = $clog2(DW);

    typedef struct packed {
        eng_state_e       state;
        attr_t            attr;
        logic [DW-1:0]    txw;
        logic [DW-1:0]    rxw;
        logic [IW-1:0]    idx;
        logic [HW-1:0]    h;
        logic [DIV_W-1:0] cnt;
        logic             sck;
        logic             cs_n;
        logic             wr;
        logic [DW-1:0]    wdata;
    } eng_t;

    eng_t q, d;

    function automatic logic [IW-1:0] frame_bits(attr_t a);
        if (a.fsz < FSZ_W'(3)) return IW'(4);
        return IW'(a.fsz) + IW'(1);
    endfunction

    function automatic logic [DW-1:0] bitrev(logic [DW-1:0] v);
        logic [DW-1:0] r;
        for (int i = 0; i < DW; i++) r[i] = v[DW-1-i];
        return r;
    endfunction

    logic [IW-1:0] n;
    logic [BW-1:0] pos;
    logic          sample;

    always_comb begin
        d       = q;
        d.wr    = 1'b0;
        tx_take = 1'b0;
        n       = frame_bits(q.attr);
        // edge number h+1 is leading when h is even
        sample  = (~q.h[0]) == (~q.attr.cpha);
        unique case (q.state)
            ST_IDLE: begin
                d.cs_n = 1'b1;
                if (tx_avail && rx_room) begin
                    tx_take = 1'b1;
                    d.attr  = tx_attr;
                    d.txw   = tx_data;
                    d.rxw   = '0;
                    d.idx   = '0;
                    d.h     = '0;
                    d.cnt   = '0;
                    d.sck   = tx_attr.cpol;
                    d.cs_n  = 1'b0;
                    d.state = ST_XFER;
                end
            end
            ST_XFER: begin
                if (q.cnt != q.attr.div) begin
                    d.cnt = q.cnt + 1'b1;
                end else begin
                    d.cnt = '0;
                    if (q.h < HW'({n, 1'b0})) begin
                        if (sample) begin
                            d.rxw = {q.rxw[DW-2:0], miso};
                        end else if (q.attr.cpha ? (q.h != '0)
                                                 : (q.h != HW'({n, 1'b0}) - 1'b1)) begin
                            d.idx = q.idx + 1'b1;
                        end
                        d.sck = ~q.sck;
                        d.h   = q.h + 1'b1;
                    end else begin
                        d.cs_n  = 1'b1;
                        d.wr    = 1'b1;
                        d.wdata = q.attr.lsbf ? (bitrev(q.rxw) >> (IW'(DW) - n)) : q.rxw;
                        d.state = ST_GAP;
                    end
                end
            end
            ST_GAP: begin
                if (q.cnt == q.attr.div) begin
                    d.cnt   = '0;
                    d.state = ST_IDLE;
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_comb begin
        pos  = q.attr.lsbf ? BW'(q.idx) : BW'(n - 1'b1 - q.idx);
        mosi = (q.state == ST_XFER) ? q.txw[pos] : 1'b0;
    end

    assign sck     = q.sck;
    assign cs_n    = q.cs_n;
    assign rx_wr   = q.wr;
    assign rx_data = q.wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.state <= ST_IDLE;
            q.cs_n  <= 1'b1;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/qspi_master.sv
module qspi_master
    import qspi_pkg::*;
#(
    parameter  int N_ATTR    = 8,
    parameter  int TXQ_DEPTH = 4,
    parameter  int RXQ_DEPTH = 5,
    localparam int SW        = $clog2(N_ATTR),
    localparam int RLW       = $clog2(RXQ_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [SW-1:0]     cfg_sel,
    input  logic [ATTR_W-1:0] cfg_wdata,
    input  logic              push_we,
    input  logic [DW-1:0]     push_word,
    input  logic [SW-1:0]     push_sel,
    output logic              push_full,
    input  logic              pop_re,
    output logic [2*DW-1:0]   pop_word,
    output logic [RLW-1:0]    rx_level,
    output logic              ovf_err,
    output logic              unf_err,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso
);

    localparam int TLW = $clog2(TXQ_DEPTH + 1);

    typedef struct packed {
        logic ovf;
        logic unf;
    } flag_t;

    flag_t flag_q, flag_d;

    logic [SW+DW-1:0] tx_head;
    logic             tx_empty, tx_take;
    logic [TLW-1:0]   tx_level;
    attr_t            head_attr;
    logic             rx_wr, rx_full, rx_empty;
    logic [DW-1:0]    rx_wdata, rx_head;

    qspi_attr_bank #(.N_ATTR(N_ATTR)) i_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wsel  (cfg_sel),
        .wattr (attr_t'(cfg_wdata)),
        .rsel  (tx_head[SW+DW-1:DW]),
        .rattr (head_attr)
    );

    qspi_fifo #(.W(SW + DW), .DEPTH(TXQ_DEPTH)) i_txq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (push_we),
        .wdata ({push_sel, push_word}),
        .rd    (tx_take),
        .rdata (tx_head),
        .full  (push_full),
        .empty (tx_empty),
        .level (tx_level)
    );

    qspi_fifo #(.W(DW), .DEPTH(RXQ_DEPTH)) i_rxq (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (rx_wr),
        .wdata (rx_wdata),
        .rd    (pop_re),
        .rdata (rx_head),
        .full  (rx_full),
        .empty (rx_empty),
        .level (rx_level)
    );

    qspi_engine i_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_avail (!tx_empty && tx_level != '0),
        .rx_room  (!rx_full),
        .tx_data  (tx_head[DW-1:0]),
        .tx_attr  (head_attr),
        .tx_take  (tx_take),
        .rx_wr    (rx_wr),
        .rx_data  (rx_wdata),
        .sck      (spi_sck),
        .cs_n     (spi_cs_n),
        .mosi     (spi_mosi),
        .miso     (spi_miso)
    );

    always_comb begin
        flag_d = flag_q;
        if (push_we && push_full) flag_d.ovf = 1'b1;
        if (pop_re && rx_empty)   flag_d.unf = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= '0;
        else        flag_q <= flag_d;
    end

    assign pop_word = {{DW{1'b0}}, rx_head};
    assign ovf_err  = flag_q.ovf;
    assign unf_err  = flag_q.unf;

endmodule

// File: rtl/qspi_master_chk.sv
module qspi_master_chk #(
    parameter  int DW        = 16,
    parameter  int RXQ_DEPTH = 5,
    localparam int RLW       = $clog2(RXQ_DEPTH + 1)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           spi_cs_n,
    input logic           spi_sck,
    input logic           push_we,
    input logic           push_full,
    input logic           pop_re,
    input logic [2*DW-1:0] pop_word,
    input logic [RLW-1:0] rx_level,
    input logic           ovf_err,
    input logic           unf_err,
    input logic           rx_wr,
    input logic           rx_full
);

    // R4: serial clock quiet while chip select stays high
    assert_sck_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n)) |-> $stable(spi_sck));

    // R9: receive FIFO never written while full
    assert_no_rx_overflow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_wr |-> !rx_full);

    // R9: level bound
    assert_level_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rx_level <= RLW'(RXQ_DEPTH));

    // R9: a frame begins only with receive room
    assert_start_room_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(spi_cs_n) |-> ($past(rx_level) < RLW'(RXQ_DEPTH)));

    // R8: upper half of the read word is zero
    assert_upper_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pop_word[2*DW-1:DW] == '0);

    // R11: push on full raises the flag, and it stays
    assert_ovf_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_we && push_full) |=> ovf_err);
    assert_ovf_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |=> ovf_err);

    // R12: pop on empty raises the flag, leaves the level alone
    assert_unf_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_re && rx_level == '0) |=> unf_err);
    assert_unf_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        unf_err |=> unf_err);
    assert_unf_level_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_re && rx_level == '0 && !rx_wr) |=> (rx_level == '0));

endmodule

bind qspi_master qspi_master_chk #(.DW(qspi_pkg::DW), .RXQ_DEPTH(RXQ_DEPTH)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_sck   (spi_sck),
    .push_we   (push_we),
    .push_full (push_full),
    .pop_re    (pop_re),
    .pop_word  (pop_word),
    .rx_level  (rx_level),
    .ovf_err   (ovf_err),
    .unf_err   (unf_err),
    .rx_wr     (rx_wr),
    .rx_full   (rx_full)
);

// File: tb/test_qspi_master.sv
module test_qspi_master;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_sel = '0;
    logic [14:0] cfg_wdata = '0;
    logic        push_we = 1'b0;
    logic [15:0] push_word = '0;
    logic [2:0]  push_sel = '0;
    logic        push_full;
    logic        pop_re = 1'b0;
    logic [31:0] pop_word;
    logic [2:0]  rx_level;
    logic        ovf_err, unf_err;
    logic        spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 1'b0;

    qspi_master i_qspi_master (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .push_we(push_we), .push_word(push_word), .push_sel(push_sel), .push_full(push_full),
        .pop_re(pop_re), .pop_word(pop_word), .rx_level(rx_level),
        .ovf_err(ovf_err), .unf_err(unf_err),
        .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [2:0]  sel;
        logic [15:0] data;
        logic [15:0] reply;
    } frame_t;

    frame_t      exp_frames[$];
    logic [15:0] exp_rx[$];
    logic [14:0] mirror[8];
    int          checks = 0;
    int          fails  = 0;
    bit          done   = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    function automatic int nbits(logic [14:0] a);
        int c = int'(a[11:8]);
        return (c < 3) ? 4 : c + 1;
    endfunction

    function automatic logic [15:0] mask(int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    function automatic logic [15:0] rev_n(logic [15:0] v, int n);
        logic [15:0] r = '0;
        for (int i = 0; i < n; i++) r[i] = v[n-1-i];
        return r;
    endfunction

    function automatic logic [14:0] mk(bit lsbf, bit cpha, bit cpol, int fsz, int div);
        return {lsbf, cpha, cpol, 4'(fsz), 8'(div)};
    endfunction

    task automatic cfg(input logic [2:0] sel, input logic [14:0] w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = w;
        @(negedge clk);
        cfg_we = 1'b0;
        mirror[sel] = w;
    endtask

    // driver: records the expected frame and received word, then pushes
    task automatic push_frame(input logic [2:0] sel, input logic [15:0] data,
                              input logic [15:0] reply);
        frame_t f;
        @(negedge clk);
        while (push_full) @(negedge clk);
        f.sel = sel; f.data = data; f.reply = reply;
        exp_frames.push_back(f);
        exp_rx.push_back(reply & mask(nbits(mirror[sel])));
        push_we = 1'b1; push_sel = sel; push_word = data;
        @(negedge clk);
        push_we = 1'b0;
    endtask

    task automatic pop_check();
        logic [15:0] e;
        @(negedge clk);
        while (rx_level == 0) @(negedge clk);
        e = exp_rx.pop_front();
        chk(pop_word[15:0] == e, "R7", "received word", pop_word[15:0], e);
        chk(pop_word[31:16] == 16'h0, "R8", "upper half", pop_word[31:16], 0);
        pop_re = 1'b1;
        @(negedge clk);
        pop_re = 1'b0;
    endtask

    // monitor: slave model plus frame-shape scoreboard
    initial begin : monitor
        longint t_fall, t_last, t_rise, prev_rise;
        int     prev_div;
        bit     have_prev = 0;
        forever begin
            frame_t      f;
            logic [14:0] a;
            int          n, div, edges, bi, bad_half;
            bit          cpol, cpha, lsbf;
            logic [15:0] cap, rep;
            @(negedge spi_cs_n);
            t_fall = $time;
            if (exp_frames.size() == 0) begin
                chk(0, "R11", "unexpected frame", 1, 0);
                continue;
            end
            f    = exp_frames.pop_front();
            a    = mirror[f.sel];
            n    = nbits(a);
            div  = int'(a[7:0]);
            cpol = a[12]; cpha = a[13]; lsbf = a[14];
            rep  = f.reply & mask(n);
            if (have_prev)
                chk((t_fall - prev_rise) / CLK_PERIOD >= prev_div + 1, "R10",
                    "chip select gap", (t_fall - prev_rise) / CLK_PERIOD, prev_div + 1);
            #1;
            chk(spi_sck == cpol, "R4", "idle polarity at start", spi_sck, cpol);
            spi_miso = lsbf ? rep[0] : rep[n-1];
            t_last = t_fall; edges = 0; bi = 0; cap = '0; bad_half = 0;
            while (1) begin
                @(spi_sck or posedge spi_cs_n);
                if (spi_cs_n) break;
                edges++;
                if ((($time - t_last) / CLK_PERIOD) != div + 1) bad_half++;
                t_last = $time;
                if ((spi_sck != cpol) == (cpha == 1'b0)) begin
                    cap = {cap[14:0], spi_mosi};
                    bi++;
                    #1;
                    if (bi < n) spi_miso = lsbf ? rep[bi] : rep[n-1-bi];
                end
            end
            t_rise = $time;
            spi_miso = 1'b0;
            chk(edges == 2 * n, "R4", "edge count", edges, 2 * n);
            chk(bad_half == 0, "R4", "half periods off", bad_half, 0);
            chk((t_rise - t_last) / CLK_PERIOD == div + 1, "R10", "trail half period",
                (t_rise - t_last) / CLK_PERIOD, div + 1);
            if (lsbf) cap = rev_n(cap, n);
            // R2 R3 R5 R6: transmitted bits match selected attributes
            chk(cap == (f.data & mask(n)), "R2", $sformatf("tx word sel %0d", f.sel),
                cap, f.data & mask(n));
            prev_rise = t_rise; prev_div = div; have_prev = 1;
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : stimulus
        for (int i = 0; i < 8; i++) mirror[i] = mk(0, 0, 0, 15, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13 reset state
        chk(spi_cs_n == 1'b1, "R13", "cs after reset", spi_cs_n, 1);
        chk(rx_level == 0, "R13", "rx level after reset", rx_level, 0);
        chk(push_full == 0, "R13", "push_full after reset", push_full, 0);
        chk(ovf_err == 0 && unf_err == 0, "R13", "flags after reset", {ovf_err, unf_err}, 0);

        // R1 attribute writes (entry 7 keeps its reset value)
        cfg(0, mk(0, 0, 0, 15, 1));
        cfg(1, mk(0, 0, 1, 7, 0));
        cfg(2, mk(1, 1, 0, 11, 2));
        cfg(3, mk(1, 1, 1, 3, 3));
        cfg(4, mk(0, 1, 0, 1, 0));   // R3 size code below 3 -> 4 bits
        cfg(5, mk(1, 0, 0, 9, 0));

        // R2 R5 R6 mixed selectors back to back
        push_frame(0, 16'hA5C3, 16'h3C5A);
        push_frame(1, 16'h00E7, 16'h0081);
        push_frame(2, 16'h0B2D, 16'h0F19);
        push_frame(3, 16'hFFF6, 16'h0009);
        push_frame(4, 16'h000B, 16'hFFF5);
        push_frame(5, 16'h02B1, 16'h0356);
        push_frame(7, 16'h1234, 16'hFEDC);   // R1 reset attributes
        for (int i = 0; i < 7; i++) pop_check();

        // R9 stall: fill receive FIFO, then the queue
        for (int i = 0; i < 9; i++) push_frame(1, 16'(8'h11 * (i + 1)), 16'(8'hF0 - i));
        @(negedge clk);
        while (!push_full) @(negedge clk);
        repeat (40) @(negedge clk);
        chk(rx_level == 5, "R9", "rx level at stall", rx_level, 5);
        chk(spi_cs_n == 1'b1, "R9", "stalled between frames", spi_cs_n, 1);
        chk(ovf_err == 0, "R11", "ovf before overflow", ovf_err, 0);

        // R11 push on full is dropped
        push_we = 1'b1; push_sel = 3'd0; push_word = 16'hDEAD;
        @(negedge clk);
        push_we = 1'b0;
        chk(ovf_err == 1, "R11", "ovf after push on full", ovf_err, 1);
        for (int i = 0; i < 9; i++) pop_check();
        repeat (60) @(negedge clk);
        chk(exp_frames.size() == 0 && rx_level == 0, "R11", "no extra frame",
            rx_level, 0);

        // R12 pop on empty
        chk(unf_err == 0, "R12", "unf before underflow", unf_err, 0);
        pop_re = 1'b1;
        @(negedge clk);
        pop_re = 1'b0;
        chk(unf_err == 1, "R12", "unf after pop on empty", unf_err, 1);
        chk(rx_level == 0, "R12", "level unchanged", rx_level, 0);
        repeat (5) @(negedge clk);
        finish_run();
    end

endmodule